// File: doc/BRIEF.md
# AGC Update Synchronization Controller

This block decides the cycle in which a gain control loop starts a new averaging and decimation update. A request can come from an external sync pin or from a software command written through a small control word. Pin requests pass through a two-stage synchronizer and a rising-edge detector. Each detected edge then starts a programmable 16-bit hold-off down-counter, and the update begins when the counter runs out. Software requests skip the counter and start the update at once.

The block has two outputs. One is a single-cycle start-of-decimation pulse. The other is an accumulator-clear pulse that comes with the start pulse when that option is enabled. A first-edge-only option lets one pin edge through and then blocks all later pin edges until software clears the option. The decimator, the power averaging and the loop arithmetic are outside this block.

Top module: `agc_sync_ctrl`

## Requirements
- R1: After synchronous reset, `start_o` and `acc_clr_o` are low, the hold-off counter is idle, and the first-edge-only and clear-on-sync options are both off.
- R2: Take a `sync_pin_i` rising edge that is set up before clock edge k, with `holdoff_i` = N ≥ 1. Then `start_o` is high for exactly one cycle, the one that follows clock edge k+2+N.
- R3: When `holdoff_i` is zero, pin edges produce no start pulse.
- R4: A pin held high makes only one trigger. It must go low and rise again before it can trigger a second time.
- R5: A new pin edge that arrives while the counter is still running reloads the counter. The pending start is dropped, and the delay is counted again from the new edge.
- R6: With the first-edge-only option set (control word bit 1), only the first pin edge is accepted. Every later pin edge is ignored.
- R7: Writing the control word with bit 1 cleared re-arms the first-edge latch. When the option is set again, the next pin edge is accepted.
- R8: A write with control word bit 0 set raises `start_o` in the cycle after that write edge, without using the counter. The bit is not stored, so a later write with bit 0 clear gives no start.
- R9: With the clear-on-sync option stored (control word bit 2), `acc_clr_o` pulses together with every start pulse, whether the start came from the pin or from the command. With the option clear, `acc_clr_o` stays low.
- R10: When a command write and a counter expiry fall in the same cycle, the block gives one start pulse lasting a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_pin_i | input | 1 | Asynchronous external sync request |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 3 | Control word: bit0 immediate sync, bit1 first-edge-only, bit2 clear-on-sync |
| holdoff_i | input | 16 | Hold-off count in clock cycles (0 disables pin sync) |
| start_o | output | 1 | Start-of-decimation pulse |
| acc_clr_o | output | 1 | Accumulator clear pulse |

## Verification
The assertions take three things for granted. `holdoff_i` does not change while a count is running. Writes are single-cycle strobes. The pin is low or steady across each reset release. The stimulus follows these rules by setting the hold-off value only while the counter is idle, by driving each write for exactly one cycle, and by keeping the pin low between scenarios. Coincidence is created on purpose in one case only: a command write placed on the exact cycle of a counter expiry.

// File: rtl/agc_sync_pkg.sv
package agc_sync_pkg;

    localparam int CTRL_W        = 3;
    localparam int BIT_SYNC_NOW  = 0;
    localparam int BIT_FIRST     = 1;
    localparam int BIT_CLR_ON    = 2;

    typedef struct packed {
        logic clr_on_sync;
        logic first_only;
        logic sync_now;
    } ctrl_word_t;

    typedef struct packed {
        logic clr_on_sync;
        logic first_only;
    } ctrl_cfg_t;

    typedef struct packed {
        logic from_cmd;
        logic from_pin;
    } start_src_t;

    function automatic logic any_start(input start_src_t s);
        return s.from_cmd | s.from_pin;
    endfunction

endpackage

// File: rtl/agc_sync_edge.sv
module agc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic trig_o
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q <= '0;
                else       sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q <= '0;
                else       sync_q <= {sync_q[MSB-1:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= sync_q[MSB];
    end

    assign trig_o = sync_q[MSB] & ~prev_q;

    // R4: a held level never yields two consecutive triggers
    p_one_shot_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        trig_o |=> !trig_o);

endmodule

// File: rtl/agc_sync_gate.sv
module agc_sync_gate (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_i,
    input  logic first_only_i,
    output logic accept_o
);
    logic seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)              seen_q <= 1'b0;
        else if (!first_only_i) seen_q <= 1'b0;
        else if (trig_i)        seen_q <= 1'b1;
    end

    assign accept_o = trig_i & ~(first_only_i & seen_q);

    // R7: dropping the option re-arms the latch
    p_rearm_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !first_only_i |=> (trig_i |-> accept_o));

endmodule

// File: rtl/agc_holdoff_cnt.sv
module agc_holdoff_cnt #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expire_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)            cnt_q <= '0;
        else if (load_i)      cnt_q <= value_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - ONE;
    end

    assign expire_o = (cnt_q == ONE) && !load_i;

    // R2: a running count steps down by one each cycle
    p_countdown_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    // R3: loading zero leaves the counter idle
    p_zero_idle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && value_i == '0) |=> (cnt_q == '0 && !expire_o));

    // R5: a reload never expires in the same cycle
    p_reload_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |-> !expire_o);

endmodule

// File: rtl/agc_sync_ctrl.sv
module agc_sync_ctrl #(
    parameter int HOLD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             sync_pin_i,
    input  logic                             ctrl_wr_i,
    input  logic [agc_sync_pkg::CTRL_W-1:0]  ctrl_wdata_i,
    input  logic [HOLD_W-1:0]                holdoff_i,
    output logic                             start_o,
    output logic                             acc_clr_o
);
    import agc_sync_pkg::*;

    ctrl_word_t wr_word;
    ctrl_cfg_t  cfg_q;
    start_src_t src;
    logic       trig, accept, expire, start_q, clr_q;

    assign wr_word = ctrl_word_t'(ctrl_wdata_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '0;
        end else if (ctrl_wr_i) begin
            cfg_q.first_only  <= wr_word.first_only;
            cfg_q.clr_on_sync <= wr_word.clr_on_sync;
        end
    end

    agc_sync_edge #(.STAGES(SYNC_STAGES)) edge_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .pin_i (sync_pin_i),
        .trig_o(trig)
    );

    agc_sync_gate gate_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .trig_i      (trig),
        .first_only_i(cfg_q.first_only),
        .accept_o    (accept)
    );

    agc_holdoff_cnt #(.W(HOLD_W)) cnt_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (accept),
        .value_i (holdoff_i),
        .expire_o(expire)
    );

    assign src.from_cmd = ctrl_wr_i & wr_word.sync_now;
    assign src.from_pin = expire;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            start_q <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            start_q <= any_start(src);
            clr_q   <= any_start(src) & cfg_q.clr_on_sync;
        end
    end

    assign start_o   = start_q;
    assign acc_clr_o = clr_q;

    // R8: an immediate command starts an update on the next cycle
    p_cmd_start_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_wr_i && ctrl_wdata_i[BIT_SYNC_NOW]) |=> start_o);

    // R9: the clear pulse only ever accompanies a start
    p_clr_with_start_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        acc_clr_o |-> start_o);

    // R6: a blocked pin edge never reaches the counter
    p_blocked_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (trig && !accept) |-> cfg_q.first_only);

endmodule

// File: tb/agc_sync_ctrl_tb_top.sv
module agc_sync_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        pin;
    logic        wr;
    logic [2:0]  wdata;
    logic [15:0] hold;
    logic        start_w, clr_w;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    agc_sync_ctrl dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .sync_pin_i  (pin),
        .ctrl_wr_i   (wr),
        .ctrl_wdata_i(wdata),
        .holdoff_i   (hold),
        .start_o     (start_w),
        .acc_clr_o   (clr_w)
    );

    typedef struct packed {
        int hv;
        int a1; int b1;
        int a2; int b2;
        int first;
        int count;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1,  1, 3,  0, -1, 4,  1},  // R2 minimum delay
        '{2,  1, 3,  0, -1, 5,  1},  // R2
        '{5,  1, 3,  0, -1, 8,  1},  // R2
        '{16, 1, 2,  0, -1, 19, 1},  // R2
        '{0,  1, 3,  0, -1, 0,  0},  // R3 disabled
        '{3,  1, 20, 0, -1, 6,  1},  // R4 held pin
        '{10, 1, 2,  6, 8,  18, 1},  // R5 retrigger
        '{2,  1, 2,  10, 11, 5, 2}   // R2 two separate edges
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_window(input int a1, input int b1, input int a2, input int b2,
                              output int first, output int cnt, output int clr_cnt);
        first = 0; cnt = 0; clr_cnt = 0;
        for (int i = 1; i <= 40; i++) begin
            pin = ((i >= a1) && (i <= b1)) || ((i >= a2) && (i <= b2));
            @(posedge clk); @(negedge clk);
            if (start_w) begin
                cnt++;
                if (first == 0) first = i;
            end
            if (clr_w) clr_cnt++;
        end
        pin = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] v);
        wr = 1'b1; wdata = v;
        @(posedge clk); @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int f, c, k;
        rst = 1'b1; pin = 1'b0; wr = 1'b0; wdata = '0; hold = 16'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 start after reset", start_w, 0);
        check("R1 clear after reset", clr_w, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: options off after reset, so a sync now gives no clear
        do_write(3'b001);
        check("R1 no clear option at reset", clr_w, 0);
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            hold = VECS[v].hv[15:0];
            run_window(VECS[v].a1, VECS[v].b1, VECS[v].a2, VECS[v].b2, f, c, k);
            check("R2/R3/R4/R5 first start cycle", f, VECS[v].first);
            check("R2/R3/R4/R5 start count", c, VECS[v].count);
        end

        // R8: immediate sync, then self clearing
        hold = 16'd0;
        wr = 1'b1; wdata = 3'b001;
        @(posedge clk); @(negedge clk);
        wr = 1'b0; wdata = '0;
        check("R8 immediate start", start_w, 1);
        @(negedge clk);
        check("R8 single cycle", start_w, 0);
        do_write(3'b000);
        check("R8 bit not stored", start_w, 0);
        @(negedge clk);
        check("R8 still idle", start_w, 0);

        // R9: clear pulse with command start and with pin start
        do_write(3'b100);
        do_write(3'b101);
        check("R9 clear with command start", clr_w, 1);
        hold = 16'd2;
        run_window(1, 2, 0, -1, f, c, k);
        check("R9 clear count with pin start", k, 1);
        do_write(3'b000);
        do_write(3'b001);
        check("R9 no clear when option off", clr_w, 0);
        @(negedge clk);

        // R6: only first pin edge accepted
        do_write(3'b010);
        hold = 16'd2;
        run_window(1, 2, 10, 11, f, c, k);
        check("R6 first edge only", c, 1);
        run_window(1, 2, 0, -1, f, c, k);
        check("R6 later edge ignored", c, 0);

        // R7: clearing option re-arms
        do_write(3'b000);
        @(negedge clk);
        do_write(3'b010);
        run_window(1, 2, 0, -1, f, c, k);
        check("R7 re-armed edge accepted", c, 1);
        do_write(3'b000);
        @(negedge clk);

        // R10: command coincides with expiry (hold 1: expiry feeds edge 4)
        hold = 16'd1;
        c = 0;
        for (int i = 1; i <= 12; i++) begin
            pin = (i <= 3);
            wr = (i == 4); wdata = (i == 4) ? 3'b001 : 3'b000;
            @(posedge clk); @(negedge clk);
            if (start_w) c++;
            if (i == 4) check("R10 start on coincident cycle", start_w, 1);
            if (i == 5) check("R10 single cycle after coincidence", start_w, 0);
        end
        wr = 1'b0; wdata = '0; pin = 1'b0;
        check("R10 one pulse total", c, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule